// File: doc/BRIEF.md
# Dual-Source Interrupt Down-Counter

This block is the interrupt timer of a cartridge controller. The CPU writes to it at four decoded addresses. These writes set an 8-bit reload value, arm the counter and pick its clock source, and mask or unmask the interrupt. The counter then counts down in one of two ways. In scanline mode it counts qualified scanline events. In CPU mode it counts CPU cycles divided by four. When the counter steps from zero into its expired state while the interrupt is unmasked, a level interrupt request rises and stays high until software masks it.

A reload-pending flag ties the counter to the reload value. Arming sets the flag. While the flag is set, a write of a new reload value, a mask write or an unmask write also copies the reload value into the counter. In scanline mode every scanline event clears the flag, and raising the interrupt sets it again. This lets the interrupt handler rearm the next split with a single write. Scanline detection and bank mapping belong to other blocks.

The register write port is a plain strobe: every write is accepted in the cycle it is presented. There is no back-pressure, and the tick inputs are single-cycle pulses that cannot be stalled.

Top module: `irq_downcount`

## Requirements
- R1: Writes are decoded from address bits [15:12] and [1:0] only (address AND 0xF003). 0xC000 is the reload-value write, 0xC001 the arm write, 0xE000 the mask write and 0xE001 the unmask write. A write to any other decoded address changes nothing.
- R2: A reload-value write stores data[7:0]. If the reload-pending flag is set, the counter is also loaded with that new value.
- R3: An arm write sets the reload-pending flag, loads the counter from the stored reload value and takes data bit 0 as the mode: 1 selects CPU mode, 0 selects scanline mode.
- R4: In CPU mode a 2-bit prescaler counts cpu_tick pulses, and every fourth pulse decrements the counter; scanline events are ignored. In scanline mode cpu_tick is ignored and the prescaler holds its value.
- R5: In scanline mode every line_tick clears the reload-pending flag. It decrements the counter only when line_visible and render_on are both high.
- R6: The counter is 9 bits wide, and its top bit marks it as expired. It decrements only while not expired. Stepping from 0 to expired raises irq if the interrupt is unmasked. If the interrupt is masked, the counter expires silently and stays expired until it is reloaded.
- R7: A mask write disables the interrupt and drops irq. If the reload-pending flag is set, it also reloads the counter.
- R8: An unmask write enables the interrupt. If the reload-pending flag is set, it also reloads the counter. Once raised, irq stays high until a mask write.
- R9: In scanline mode, raising irq also sets the reload-pending flag.
- R10: Reset clears the enable, mode, counter, reload value, prescaler, reload-pending flag and irq.
- R11: When a write and a count event land in the same cycle, the write wins for every field it writes. Reload decisions use the flag value held before that cycle.
- R12: irq is registered. It changes on the clock edge that samples the causing event or write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| cpu_tick | input | 1 | One pulse per CPU cycle |
| line_tick | input | 1 | One pulse per scanline event |
| line_visible | input | 1 | Current scanline is a visible line |
| render_on | input | 1 | Rendering is enabled |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong counter value shows up as irq rising early or late. The offset is a whole number of scanline events, or of four-cycle prescaler periods, relative to the reload value, so a sweep of reload values exposes it on the first expiry. A stuck or missing reload-pending flag only shows on the next expiry after a reload-value or mask write: either the interrupt fires after the old count, or it never fires again. A prescaler that drifts in scanline mode moves the first CPU-mode expiry by one to three ticks.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_RELOAD_VAL,
    CMD_ARM,
    CMD_MASK,
    CMD_UNMASK
  } cmd_t;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output cmd_t              cmd
);
  // Only the top nibble and the two low bits take part in decoding.
  localparam logic [ADDR_W-1:0] SEL_MASK = {4'hF, {(ADDR_W-6){1'b0}}, 2'b11};
  localparam logic [ADDR_W-1:0] A_RVAL   = {4'hC, {(ADDR_W-6){1'b0}}, 2'b00};
  localparam logic [ADDR_W-1:0] A_ARM    = {4'hC, {(ADDR_W-6){1'b0}}, 2'b01};
  localparam logic [ADDR_W-1:0] A_MASK   = {4'hE, {(ADDR_W-6){1'b0}}, 2'b00};
  localparam logic [ADDR_W-1:0] A_UNMASK = {4'hE, {(ADDR_W-6){1'b0}}, 2'b01};

  logic [ADDR_W-1:0] sel;
  assign sel = wr_addr & SEL_MASK;

  always_comb begin
    cmd = CMD_NONE;
    if (wr_en) begin
      unique case (sel)
        A_RVAL:   cmd = CMD_RELOAD_VAL;
        A_ARM:    cmd = CMD_ARM;
        A_MASK:   cmd = CMD_MASK;
        A_UNMASK: cmd = CMD_UNMASK;
        default:  cmd = CMD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/irqc_prescale.sv
module irqc_prescale #(
  parameter int PRE_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  output logic             step,
  output logic [PRE_W-1:0] pre_o
);
  localparam logic [PRE_W-1:0] WRAP = {PRE_W{1'b1}};

  logic [PRE_W-1:0] pre_q;

  // A step fires on the tick that wraps the prescaler.
  assign step  = run && tick && (pre_q == WRAP);
  assign pre_o = pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (run && tick) begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/irqc_core.sv
module irqc_core
  import irqc_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_t              cmd,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cpu_step,
  input  logic              line_tick,
  input  logic              line_ok,
  output logic              irq,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              mode_o,
  output logic              en_o
);
  localparam int TOP = CNT_W - 1;

  logic [DATA_W-1:0] rval_q, rval_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              rel_q, rel_d;
  logic              en_q, en_d;
  logic              mode_q, mode_d;
  logic              irq_q, irq_d;
  logic              dec;
  logic [CNT_W-1:0]  reload_cnt;

  assign reload_cnt = {1'b0, rval_q};
  // mode_q = 1: CPU-cycle source, 0: scanline source
  assign dec = mode_q ? cpu_step : (line_tick && line_ok);

  always_comb begin
    rval_d = rval_q;
    cnt_d  = cnt_q;
    rel_d  = rel_q;
    en_d   = en_q;
    mode_d = mode_q;
    irq_d  = irq_q;

    // Count event first.
    if (!mode_q && line_tick) rel_d = 1'b0;
    if (dec && !cnt_q[TOP]) begin
      cnt_d = cnt_q - {{(CNT_W-1){1'b0}}, 1'b1};
      if (cnt_q == '0 && en_q) begin
        irq_d = 1'b1;
        if (!mode_q) rel_d = 1'b1;
      end
    end

    // Register write overrides the fields it touches.
    unique case (cmd)
      CMD_RELOAD_VAL: begin
        rval_d = wr_data;
        if (rel_q) cnt_d = {1'b0, wr_data};
      end
      CMD_ARM: begin
        rel_d  = 1'b1;
        cnt_d  = reload_cnt;
        mode_d = wr_data[0];
      end
      CMD_MASK: begin
        en_d  = 1'b0;
        irq_d = 1'b0;
        if (rel_q) cnt_d = reload_cnt;
      end
      CMD_UNMASK: begin
        en_d = 1'b1;
        if (rel_q) cnt_d = reload_cnt;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rval_q <= '0;
      cnt_q  <= '0;
      rel_q  <= 1'b0;
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      rval_q <= rval_d;
      cnt_q  <= cnt_d;
      rel_q  <= rel_d;
      en_q   <= en_d;
      mode_q <= mode_d;
      irq_q  <= irq_d;
    end
  end

  assign irq    = irq_q;
  assign cnt_o  = cnt_q;
  assign mode_o = mode_q;
  assign en_o   = en_q;
endmodule

// File: rtl/irq_downcount.sv
module irq_downcount
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PRE_W  = 2,
  localparam int CNT_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cpu_tick,
  input  logic              line_tick,
  input  logic              line_visible,
  input  logic              render_on,
  output logic              irq
);
  cmd_t             cmd;
  logic             cpu_step;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             mode_q;
  logic             en_q;

  irqc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .cmd     (cmd)
  );

  irqc_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (mode_q),
    .tick  (cpu_tick),
    .step  (cpu_step),
    .pre_o (pre_q)
  );

  irqc_core #(.DATA_W(DATA_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .wr_data   (wr_data),
    .cpu_step  (cpu_step),
    .line_tick (line_tick),
    .line_ok   (line_visible && render_on),
    .irq       (irq),
    .cnt_o     (cnt_q),
    .mode_o    (mode_q),
    .en_o      (en_q)
  );
endmodule

// File: rtl/irq_downcount_chk.sv
module irq_downcount_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 9,
  parameter int PRE_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              irq,
  input logic [CNT_W-1:0]  cnt,
  input logic [PRE_W-1:0]  pre,
  input logic              mode,
  input logic              en
);
  localparam logic [ADDR_W-1:0] M  = {4'hF, {(ADDR_W-6){1'b0}}, 2'b11};
  localparam logic [ADDR_W-1:0] AM = {4'hE, {(ADDR_W-6){1'b0}}, 2'b00};

  logic mask_wr;
  assign mask_wr = wr_en && ((wr_addr & M) == AM);

  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !mask_wr |=> irq);

  // R7
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> !irq);

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (cnt == {CNT_W{1'b1}}) && en);

  // R6
  expired_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt[CNT_W-1] && !wr_en |=> cnt[CNT_W-1]);

  // R4
  prescale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |=> $stable(pre));
endmodule

bind irq_downcount irq_downcount_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PRE_W(PRE_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .irq     (irq),
  .cnt     (cnt_q),
  .pre     (pre_q),
  .mode    (mode_q),
  .en      (en_q)
);

// File: tb/sim_irq_downcount.sv
module sim_irq_downcount;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        cpu_tick = 1'b0;
  logic        line_tick = 1'b0;
  logic        line_visible = 1'b0;
  logic        render_on = 1'b0;
  logic        irq;
  int          nchk = 0;
  int          nfail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  irq_downcount u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cpu_tick(cpu_tick), .line_tick(line_tick),
    .line_visible(line_visible), .render_on(render_on), .irq(irq)
  );

  task automatic check(input bit exp, input string req, input string what);
    nchk++;
    if (irq !== exp) begin
      nfail++;
      $display("FAIL %s %s irq=%0b expected=%0b", req, what, irq, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic line(input bit vis, input bit ren);
    @(negedge clk); line_tick = 1'b1; line_visible = vis; render_on = ren;
    @(negedge clk); line_tick = 1'b0;
  endtask

  task automatic cpu(input int n);
    if (n > 0) begin
      @(negedge clk); cpu_tick = 1'b1;
      repeat (n) @(negedge clk);
      cpu_tick = 1'b0;
    end
  endtask

  // write and visible line in the same cycle
  task automatic wr_line(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    line_tick = 1'b1; line_visible = 1'b1; render_on = 1'b1;
    @(negedge clk); wr_en = 1'b0; line_tick = 1'b0;
  endtask

  initial begin
    do_reset();
    // R10: irq low, and zero counter / scanline mode / no reload after reset
    check(1'b0, "R10", "after reset");
    wr(16'hE001, 8'h00);
    check(1'b0, "R10", "unmask with cleared flag");
    line(1'b1, 1'b1);
    check(1'b1, "R10", "counter was zero in scanline mode");
    wr(16'hE000, 8'h00);
    // R7
    check(1'b0, "R7", "mask drops irq");

    // R5 R6 R12: scanline sweep, expiry after L+1 counted lines
    for (int l = 0; l <= 40; l++) begin
      do_reset();
      wr(16'hC000, 8'(l));
      wr(16'hC001, 8'h00);
      wr(16'hE001, 8'h00);
      for (int k = 0; k < l; k++) begin
        if (l % 3 == 0) begin
          line(1'b0, 1'b1);
          line(1'b1, 1'b0);
        end
        if (l % 4 == 1) cpu(7);
        line(1'b1, 1'b1);
      end
      check(1'b0, "R5", $sformatf("scanline L=%0d before expiry", l));
      line(1'b1, 1'b1);
      check(1'b1, "R6", $sformatf("scanline L=%0d at expiry", l));
    end
    do_reset();
    wr(16'hC000, 8'hFF); wr(16'hC001, 8'h00); wr(16'hE001, 8'h00);
    for (int k = 0; k < 255; k++) line(1'b1, 1'b1);
    check(1'b0, "R6", "scanline L=255 before expiry");
    line(1'b1, 1'b1);
    check(1'b1, "R6", "scanline L=255 at expiry");

    // R4: CPU sweep, expiry after 4*(L+1) ticks, scanlines ignored
    for (int l = 0; l <= 30; l++) begin
      do_reset();
      wr(16'hC000, 8'(l));
      wr(16'hC001, 8'h01);
      wr(16'hE001, 8'h00);
      if (l % 2 == 1) repeat (3) line(1'b1, 1'b1);
      cpu(4 * (l + 1) - 1);
      check(1'b0, "R4", $sformatf("cpu L=%0d one tick early", l));
      cpu(1);
      check(1'b1, "R4", $sformatf("cpu L=%0d at expiry", l));
    end

    // R6 R8 R3: silent expiry, unmask reloads while flag held
    do_reset();
    wr(16'hC000, 8'd3); wr(16'hC001, 8'h01);
    cpu(16);
    check(1'b0, "R6", "masked expiry silent");
    cpu(8);
    check(1'b0, "R6", "stays expired");
    wr(16'hE001, 8'h00);
    cpu(15);
    check(1'b0, "R8", "unmask reloaded counter, early");
    cpu(1);
    check(1'b1, "R8", "unmask reloaded counter, expiry");
    cpu(20);
    check(1'b1, "R8", "irq sticky");
    wr(16'hE000, 8'h00);
    check(1'b0, "R7", "mask clears sticky irq");

    // R1: mirrored addresses decode, unmatched ones ignored
    do_reset();
    wr(16'hCFFC, 8'd2);
    wr(16'hC005, 8'h00);
    wr(16'hEFFD, 8'h00);
    wr(16'hC002, 8'h01);
    wr(16'h8000, 8'h01);
    wr(16'hD001, 8'h01);
    repeat (2) line(1'b1, 1'b1);
    check(1'b0, "R1", "mirrored decode, before expiry");
    line(1'b1, 1'b1);
    check(1'b1, "R1", "mirrored decode, expiry; others ignored");

    // R2 R5: flag cleared by line, new reload value does not load counter
    do_reset();
    wr(16'hC000, 8'd3); wr(16'hC001, 8'h00); wr(16'hE001, 8'h00);
    line(1'b1, 1'b1);
    wr(16'hC000, 8'd10);
    repeat (2) line(1'b1, 1'b1);
    check(1'b0, "R2", "no reload after flag cleared, early");
    line(1'b1, 1'b1);
    check(1'b1, "R2", "no reload after flag cleared, expiry");
    // R9: irq set the flag, so writes reload
    wr(16'hC000, 8'd5);
    wr(16'hE000, 8'h00);
    check(1'b0, "R7", "mask after scanline irq");
    wr(16'hE001, 8'h00);
    repeat (5) line(1'b1, 1'b1);
    check(1'b0, "R9", "reloaded to 5, early");
    line(1'b1, 1'b1);
    check(1'b1, "R9", "reloaded to 5, expiry");

    // R4: prescaler holds in scanline mode
    do_reset();
    wr(16'hC001, 8'h01);
    cpu(2);
    wr(16'hC001, 8'h00);
    cpu(9);
    wr(16'hC000, 8'd1);
    wr(16'hC001, 8'h01);
    wr(16'hE001, 8'h00);
    cpu(5);
    check(1'b0, "R4", "prescaler held, early");
    cpu(1);
    check(1'b1, "R4", "prescaler held, expiry");

    // R11: mask write beats a same-cycle expiry
    do_reset();
    wr(16'hC000, 8'd0); wr(16'hC001, 8'h00); wr(16'hE001, 8'h00);
    wr_line(16'hE000, 8'h00);
    check(1'b0, "R11", "mask wins over expiry");
    wr(16'hE001, 8'h00);
    check(1'b0, "R11", "unmask after collision");
    line(1'b1, 1'b1);
    check(1'b1, "R11", "reload from write kept counter at 0");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog all=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule